// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller with IRQ/FIQ Routing

The block gathers level-sensitive interrupt requests from peripherals, up to 64 of them in two banks of 32, and presents them to a processor as two request outputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each bank holds an enable mask, a per-source routing register that picks which output a source drives, and a read-only pending view. Pending is the raw request level ANDed with the enable mask.

A third output, `wake_o`, tells the power controller that the core should leave idle. A single control bit decides how `wake_o` behaves. When the bit is set, `wake_o` follows only enabled pending sources. When the bit is clear, any raised request line wakes the core, whether it is enabled or not.

Software reaches the registers through a small read/write bus. Acknowledging a request means clearing its enable bit, because a level request stays high until the peripheral drops it. The enable masks are plain read/write storage. Software can read them, save them and write them back to restore the same enable set.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After a synchronous reset, every enable bit, every routing bit and the wake control bit are 0. `irq_o` and `fiq_o` are then 0, whatever the request lines are doing.
- R2: Register address: `bus_addr[2]` selects the bank (0 = sources 0..31, 1 = sources 32..63), and `bus_addr[1:0]` selects the register (0 = enable mask, 1 = routing, 2 = pending, 3 = control). Bit n of a bank register belongs to source 32*bank+n. Reading the pending register returns the raw request levels ANDed with that bank's enable mask.
- R3: `irq_o` is 1 exactly when some source has its request high, its enable bit 1 and its routing bit 0.
- R4: `fiq_o` is 1 exactly when some source has its request high, its enable bit 1 and its routing bit 1.
- R5: When control bit 0 (wake qualifier) is 1, `wake_o` is 1 exactly when some enabled source is pending.
- R6: When the wake qualifier is 0, `wake_o` is 1 when any request line is high, enabled or not.
- R7: Writes to the pending register are ignored: the enable and routing registers keep their values and the pending readback is unchanged.
- R8: Requests are level sensitive. An output stays high while the request is held and enabled. It drops after the source's enable bit is cleared (acknowledge) or after the request falls.
- R9: `irq_o`, `fiq_o`, `wake_o` and `bus_rdata` are registered. A change of the inputs or of a register shows up at the outputs after the next rising clock edge. `bus_rdata` reflects `bus_addr` as sampled at that edge.
- R10: Writing back a previously read enable mask restores exactly the same enable set and the same output behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level request lines, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Bank select and register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake-from-idle request |

## Verification
The bench uses source 63 at the top of the second bank, which a design with a wrong bank offset would lose or map onto source 31. It mixes routing on one source and on several sources at once; swapped routing polarity would raise `fiq_o` where `irq_o` belongs. It runs the wake qualifier both ways with only a masked source raised, where a design that ignores the bit would either wake or stay asleep wrongly. It writes to the pending register, acknowledges a held request by clearing its enable bit, and saves and restores a mask. A design that let the pending write through, or that cleared requests instead of the enable bit, would show a wrong readback or a stuck output.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_ROUTE = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_mask,
  input  logic         we_route,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] src,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] route_q,
  output logic [W-1:0] pend,
  output logic         any_irq,
  output logic         any_fiq,
  output logic         any_raw,
  output logic         any_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      if (we_mask)  mask_q  <= wdata;
      if (we_route) route_q <= wdata;
    end
  end

  always_comb begin
    pend     = src & mask_q;
    any_irq  = |(pend & ~route_q);
    any_fiq  = |(pend & route_q);
    any_raw  = |src;
    any_pend = |pend;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         irq_d,
  input  logic         fiq_d,
  input  logic         wake_d,
  input  logic [W-1:0] rdata_d,
  output logic         irq_q,
  output logic         fiq_q,
  output logic         wake_q,
  output logic [W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
      wake_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q   <= irq_d;
      fiq_q   <= fiq_d;
      wake_q  <= wake_d;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  localparam int NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BANK_W-1:0]  bus_wdata,
  output logic [BANK_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  reg_sel_e            sel;
  logic [SEL_W-1:0]    bank_idx;
  logic                wake_qual;
  logic [NUM_SRC-1:0]  mask_all;
  logic [NUM_SRC-1:0]  route_all;
  logic [NUM_SRC-1:0]  pend_all;
  logic [NUM_BANKS-1:0] b_irq, b_fiq, b_raw, b_pend;
  logic                irq_d, fiq_d, wake_d;
  logic [BANK_W-1:0]   rdata_d;

  assign sel      = reg_sel_e'(bus_addr[1:0]);
  assign bank_idx = bus_addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst)                            wake_qual <= 1'b0;
    else if (bus_we && sel == SEL_CTRL) wake_qual <= bus_wdata[0];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (int'(bank_idx) == b);
    irq_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we_mask (bus_we && hit && sel == SEL_MASK),
      .we_route(bus_we && hit && sel == SEL_ROUTE),
      .wdata   (bus_wdata),
      .src     (src_i[b*BANK_W +: BANK_W]),
      .mask_q  (mask_all[b*BANK_W +: BANK_W]),
      .route_q (route_all[b*BANK_W +: BANK_W]),
      .pend    (pend_all[b*BANK_W +: BANK_W]),
      .any_irq (b_irq[b]),
      .any_fiq (b_fiq[b]),
      .any_raw (b_raw[b]),
      .any_pend(b_pend[b])
    );
  end

  always_comb begin
    irq_d   = |b_irq;
    fiq_d   = |b_fiq;
    wake_d  = wake_qual ? (|b_pend) : (|b_raw);
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(bank_idx) == b) begin
        case (sel)
          SEL_MASK:  rdata_d = mask_all[b*BANK_W +: BANK_W];
          SEL_ROUTE: rdata_d = route_all[b*BANK_W +: BANK_W];
          SEL_PEND:  rdata_d = pend_all[b*BANK_W +: BANK_W];
          default:   rdata_d = {{(BANK_W-1){1'b0}}, wake_qual};
        endcase
      end
    end
  end

  irq_out_stage #(.W(BANK_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .irq_d  (irq_d),
    .fiq_d  (fiq_d),
    .wake_d (wake_d),
    .rdata_d(rdata_d),
    .irq_q  (irq_o),
    .fiq_q  (fiq_o),
    .wake_q (wake_o),
    .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_i,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               wake_o,
  input logic               wake_qual,
  input logic [NUM_SRC-1:0] mask_all,
  input logic [NUM_SRC-1:0] route_all
);
  // R3 / R9: a normal request needs a raised line at the previous edge
  a_r3_irq_needs_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|src_i));

  // R4 / R9: same for the fast request
  a_r4_fiq_needs_source: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(|src_i));

  // R5: with the qualifier set, a wake means some enabled source is pending
  a_r5_wake_qualified: assert property (@(posedge clk) disable iff (rst)
    (wake_o && $past(wake_qual)) |-> (irq_o || fiq_o));

  // R6: a raised output always implies a wake request
  a_r6_wake_covers_req: assert property (@(posedge clk) disable iff (rst)
    (irq_o || fiq_o) |-> wake_o);

  // R7: a write to the pending register changes no storage
  a_r7_pending_read_only: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[1:0] == 2'd2) |=> ($stable(mask_all) && $stable(route_all)));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_i    (src_i),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .wake_o   (wake_o),
  .wake_qual(wake_qual),
  .mask_all (mask_all),
  .route_all(route_all)
);

// File: tb/test_irq_mask_ctrl.sv
`timescale 1ns/1ps
module test_irq_mask_ctrl;
  localparam int CLK_NS = 20;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, wake_o;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  irq_mask_ctrl i_irq_mask_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
  );

  // vector table: mask, route, qualifier, sources, expected irq/fiq/wake
  localparam logic [63:0] V_MASK [NV] = '{
    64'h0, 64'h1, 64'h1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_ROUTE [NV] = '{
    64'h0, 64'h0, 64'h1, 64'h0, 64'h0,
    64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 64'h0};
  localparam logic V_QUAL [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [63:0] V_SRC [NV] = '{
    64'h1, 64'h1, 64'h1, 64'h8000_0000_0000_0001, 64'h1,
    64'h0000_0001_0000_0000, 64'h0000_0001_0000_0002, 64'h0};
  localparam logic [2:0] V_EXP [NV] = '{  // {irq, fiq, wake}
    3'b001, 3'b101, 3'b011, 3'b101, 3'b000, 3'b011, 3'b111, 3'b000};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] saved;
    src_i = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    check("R1 irq in reset", {63'b0, irq_o}, 64'd0);
    check("R1 fiq in reset", {63'b0, fiq_o}, 64'd0);
    @(negedge clk) rst = 1'b0;
    settle();
    check("R1 irq after reset with all lines high", {63'b0, irq_o}, 64'd0);
    check("R6 wake after reset, qualifier clear", {63'b0, wake_o}, 64'd1);
    rd(3'b000, r); check("R1 bank0 mask reset", {32'b0, r}, 64'd0);
    rd(3'b101, r); check("R1 bank1 route reset", {32'b0, r}, 64'd0);
    rd(3'b011, r); check("R1 control reset", {32'b0, r}, 64'd0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(3'b000, V_MASK[i][31:0]);
      wr(3'b100, V_MASK[i][63:32]);
      wr(3'b001, V_ROUTE[i][31:0]);
      wr(3'b101, V_ROUTE[i][63:32]);
      wr(3'b011, {31'b0, V_QUAL[i]});
      @(negedge clk) src_i = V_SRC[i];
      settle();
      check($sformatf("R3 irq vector %0d", i), {63'b0, irq_o}, {63'b0, V_EXP[i][2]});
      check($sformatf("R4 fiq vector %0d", i), {63'b0, fiq_o}, {63'b0, V_EXP[i][1]});
      check($sformatf("R5/R6 wake vector %0d", i), {63'b0, wake_o}, {63'b0, V_EXP[i][0]});
    end

    // R2: pending readback per bank
    wr(3'b011, 32'd0);
    wr(3'b001, 32'd0); wr(3'b101, 32'd0);
    wr(3'b000, 32'h0000_FF00);
    wr(3'b100, 32'h8000_000F);
    @(negedge clk) src_i = 64'h8000_0003_0000_0F0F;
    rd(3'b010, r); check("R2 bank0 pending", {32'b0, r}, 64'h0000_0F00);
    rd(3'b110, r); check("R2 bank1 pending", {32'b0, r}, 64'h8000_0003);

    // R7: writing pending is ignored
    wr(3'b110, 32'hFFFF_FFFF);
    rd(3'b100, r); check("R7 mask after pending write", {32'b0, r}, 64'h8000_000F);
    rd(3'b110, r); check("R7 pending after pending write", {32'b0, r}, 64'h8000_0003);
    rd(3'b101, r); check("R7 route after pending write", {32'b0, r}, 64'd0);

    // R9: one-cycle latency on a source edge
    wr(3'b000, 32'h1); wr(3'b100, 32'h0);
    @(negedge clk) src_i = 64'h0;
    settle();
    @(negedge clk) src_i = 64'h1;
    #1 check("R9 irq before edge", {63'b0, irq_o}, 64'd0);
    @(posedge clk); #1;
    check("R9 irq after one edge", {63'b0, irq_o}, 64'd1);

    // R8: level hold, acknowledge by clearing enable, drop of line
    repeat (4) @(posedge clk);
    #1 check("R8 irq held while line high", {63'b0, irq_o}, 64'd1);
    wr(3'b000, 32'h0);
    settle();
    check("R8 irq drops after enable cleared", {63'b0, irq_o}, 64'd0);
    wr(3'b000, 32'h1);
    settle();
    check("R8 irq returns on re-enable with line held", {63'b0, irq_o}, 64'd1);
    @(negedge clk) src_i = 64'h0;
    settle();
    check("R8 irq drops after line falls", {63'b0, irq_o}, 64'd0);

    // R10: save, clear, restore
    wr(3'b100, 32'h4000_0001);
    rd(3'b100, saved);
    wr(3'b100, 32'h0);
    wr(3'b100, saved);
    rd(3'b100, r); check("R10 restored mask readback", {32'b0, r}, 64'h4000_0001);
    @(negedge clk) src_i = 64'h4000_0000_0000_0000;
    settle();
    check("R10 restored source 62 raises irq", {63'b0, irq_o}, 64'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule